// File: doc/BRIEF.md
# Byte-Wide Memory DMA Engine

This engine copies a run of words between an external memory that is only eight bits wide and the processor's on-chip program or data RAM. Each internal word is built from, or split into, one, two or three byte accesses. The transfer format selects a 24-bit program word, a 16-bit data word, or a single byte placed in the upper or lower half of a data word. Firmware sets the format, the direction, the internal start address, the external page and offset, and the byte-access wait count. It then writes a nonzero word count, and that write starts the engine.

The external address is 22 bits wide. It is a page number above a 14-bit offset, and it advances as one number, so a run may cross from one page into the next. Whenever the processor has an external access of its own pending, the engine waits. A context-restart option keeps the processor stalled for the whole run and then signals it to begin again at address 0. When the configuration pin is high during reset, the engine loads a boot setup and starts on its own. That setup copies 32 program words from byte address 0 into program RAM address 0.

Top module: `bytemem_dma`

## Requirements
- R1: The format field `fmt` (bits 1:0 of the control register, select 0) sets the bytes per word: 00 takes three bytes into a 24-bit program word, and 01 takes two bytes into a 16-bit data word. Both 10 and 11 take one byte. Multi-byte words move most significant byte first, at consecutive byte addresses.
- R2: In format 10 the byte lands in bits 15:8 of the internal word, and in format 11 it lands in bits 7:0. Every other bit of the internal word is zero.
- R3: The byte address `bm_addr` is {page, offset}: the page comes from control bits 11:4 and the offset from select 2. It increments by one after each byte access and carries from the offset into the page. It does not change while a strobe is held.
- R4: Writing a nonzero value to the count register (select 4) starts a run, and writing zero starts nothing. `busy` is high while the count is nonzero. The count falls by one per word, and `done_irq` pulses for exactly one cycle as the count reaches zero.
- R5: Each byte strobe (`bm_rd` or `bm_wr`) stays high for wait+1 cycles. The wait count comes from select 3 and resets to 7. Each word moves to or from internal RAM with a single one-cycle `im_req`.
- R6: No byte access begins in a cycle that follows one in which `core_ext_req` was high.
- R7: With the context bit (control bit 3) set to 1, `core_hold` is high for the whole run, and `core_restart` pulses together with `done_irq`. With the bit at 0, neither output is asserted.
- R8: A reset taken with `boot_mode` high loads format 00, direction 0, page 0, offsets 0, context bit 1 and count 32, so the run starts as soon as reset is released. A reset with `boot_mode` low leaves the count at 0.
- R9: Direction (control bit 2) 0 reads bytes and writes words to internal RAM. Direction 1 reads words with `im_we` low and writes their bytes out. The internal address starts at the select 1 value and advances by one per word. `im_dm` is 0 only for format 00.
- R10: Register writes made while `busy` is high have no effect.
- R11: After a non-boot reset, `busy`, the strobes, `im_req`, `done_irq` and `core_hold` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 1 | Selects the boot setup when sampled during reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 internal address, 2 offset, 3 wait, 4 count |
| reg_wdata | input | 14 | Register write data |
| core_ext_req | input | 1 | Processor external access pending |
| bm_addr | output | 22 | Byte memory address |
| bm_rd | output | 1 | Byte read strobe |
| bm_wr | output | 1 | Byte write strobe |
| bm_wdata | output | 8 | Byte write data |
| bm_rdata | input | 8 | Byte read data |
| im_req | output | 1 | Internal RAM request, one cycle per word |
| im_we | output | 1 | Internal RAM write enable |
| im_dm | output | 1 | 1 selects data RAM, 0 selects program RAM |
| im_addr | output | 14 | Internal word address |
| im_wdata | output | 24 | Internal write word |
| im_rdata | input | 24 | Internal read word, valid the cycle after a read request |
| busy | output | 1 | Run in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| core_hold | output | 1 | Processor stall |
| core_restart | output | 1 | Restart processor at address 0 |

## Verification
The bench first takes a data-word run over the top of a page and checks the byte addresses on both sides of the crossing. A design that wrapped the offset without carrying into the page would read page 3 again in place of page 4. The single-byte formats are checked for the exact lane each byte lands in and for zero-fill. A design that swapped the lanes or left stale bits would return a wrong internal word. The remaining runs target four behaviours. A run is started under a pending processor access, and a design that ignored it would strobe at once. A second count write goes in mid-run, and a design that accepted it would add words or switch format. A count of zero is written, and a design that started on it would strobe. Finally a boot reset checks the 32-word program copy and its hold-and-restart handshake.

// File: rtl/bdma_pkg.sv
// Shared types and register selects for the byte-memory DMA engine.
package bdma_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 24;
    localparam int SEL_W  = 3;

    typedef enum logic [1:0] {
        FMT_PM24 = 2'b00,
        FMT_DM16 = 2'b01,
        FMT_HI8  = 2'b10,
        FMT_LO8  = 2'b11
    } fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_BYTE,
        ST_IMEM,
        ST_LOAD
    } seq_st_e;

    localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_IADDR = 3'd1;
    localparam logic [SEL_W-1:0] SEL_EOFF  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_WAIT  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_COUNT = 3'd4;

    // Number of byte accesses that make up one word of the given format.
    function automatic logic [1:0] bytes_per_word(input fmt_e f);
        case (f)
            FMT_PM24: return 2'd3;
            FMT_DM16: return 2'd2;
            default:  return 2'd1;
        endcase
    endfunction
endpackage

// File: rtl/bdma_regs.sv
// Configuration and progress registers. Holds format, direction, context
// bit, the combined page/offset address, internal address, wait count and
// word count. Assumes inc/dec pulses come only from the sequencer during a
// run; writes are refused while the count is nonzero.
module bdma_regs
    import bdma_pkg::*;
#(
    parameter int PAGE_W     = 8,
    parameter int OFF_W      = 14,
    parameter int IADDR_W    = 14,
    parameter int CNT_W      = 14,
    parameter int WAIT_W     = 3,
    parameter int REG_W      = 14,
    parameter int BOOT_COUNT = 32,
    parameter int RESET_WAIT = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      boot_mode,
    input  logic                      reg_we,
    input  logic [SEL_W-1:0]          reg_sel,
    input  logic [REG_W-1:0]          reg_wdata,
    input  logic                      inc_ext,
    input  logic                      inc_int,
    input  logic                      dec_cnt,
    output fmt_e                      fmt,
    output logic                      dir,
    output logic                      ctx,
    output logic [PAGE_W+OFF_W-1:0]   ext_addr,
    output logic [IADDR_W-1:0]        int_addr,
    output logic [WAIT_W-1:0]         wait_cnt,
    output logic                      cnt_nz,
    output logic                      cnt_last
);
    localparam int EXT_W    = PAGE_W + OFF_W;
    localparam int PAGE_LSB = 4;

    logic [CNT_W-1:0] cnt;
    logic             wr_ok;

    assign cnt_nz   = (cnt != '0);
    assign cnt_last = (cnt == CNT_W'(1));
    assign wr_ok    = reg_we && !cnt_nz;

    // Register update: reset defaults, idle-time writes, run-time stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt      <= FMT_PM24;
            dir      <= 1'b0;
            ctx      <= boot_mode;
            ext_addr <= '0;
            int_addr <= '0;
            wait_cnt <= WAIT_W'(RESET_WAIT);
            cnt      <= boot_mode ? CNT_W'(BOOT_COUNT) : '0;
        end else begin
            if (wr_ok) begin
                case (reg_sel)
                    SEL_CTRL: begin
                        fmt <= fmt_e'(reg_wdata[1:0]);
                        dir <= reg_wdata[2];
                        ctx <= reg_wdata[3];
                        ext_addr[EXT_W-1 -: PAGE_W] <= reg_wdata[PAGE_LSB +: PAGE_W];
                    end
                    SEL_IADDR: int_addr <= reg_wdata[IADDR_W-1:0];
                    SEL_EOFF:  ext_addr[OFF_W-1:0] <= reg_wdata[OFF_W-1:0];
                    SEL_WAIT:  wait_cnt <= reg_wdata[WAIT_W-1:0];
                    SEL_COUNT: cnt <= reg_wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
            if (inc_ext) ext_addr <= ext_addr + EXT_W'(1);
            if (inc_int) int_addr <= int_addr + IADDR_W'(1);
            if (dec_cnt) cnt      <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/bdma_pack.sv
// Byte packer/unpacker. A 24-bit shift register collects read bytes MSB
// first, or is loaded from an internal word and shifted out MSB first.
// Assumes at most one of load/shift_in/shift_out per cycle.
module bdma_pack
    import bdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_e              fmt,
    input  logic              load_word,
    input  logic              shift_in,
    input  logic              shift_out,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [WORD_W-1:0] word_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic [WORD_W-1:0] word_out
);
    logic [WORD_W-1:0] sh;

    // Shift register: align a fetched word, or move one byte per access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load_word) begin
            case (fmt)
                FMT_PM24: sh <= word_in;
                FMT_DM16: sh <= {word_in[15:0], 8'h00};
                FMT_HI8:  sh <= {word_in[15:8], 16'h0000};
                default:  sh <= {word_in[7:0], 16'h0000};
            endcase
        end else if (shift_in) begin
            sh <= {sh[15:0], byte_in};
        end else if (shift_out) begin
            sh <= {sh[15:0], 8'h00};
        end
    end

    assign byte_out = sh[WORD_W-1 -: BYTE_W];

    // Word assembly: place collected bytes per format, zero elsewhere.
    always_comb begin
        case (fmt)
            FMT_PM24: word_out = sh;
            FMT_DM16: word_out = {8'h00, sh[15:0]};
            FMT_HI8:  word_out = {8'h00, sh[7:0], 8'h00};
            default:  word_out = {16'h0000, sh[7:0]};
        endcase
    end
endmodule

// File: rtl/bdma_seq.sv
// Transfer sequencer. Arbitrates each byte access against the processor,
// times strobes with the wait count, issues one internal request per word
// and raises the completion pulse. Assumes configuration is stable while
// cnt_nz is high.
module bdma_seq
    import bdma_pkg::*;
#(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_e              fmt,
    input  logic              dir,
    input  logic [WAIT_W-1:0] wait_cnt,
    input  logic              cnt_nz,
    input  logic              cnt_last,
    input  logic              core_ext_req,
    output logic              bm_rd,
    output logic              bm_wr,
    output logic              im_req,
    output logic              im_we,
    output logic              shift_in,
    output logic              shift_out,
    output logic              load_word,
    output logic              inc_ext,
    output logic              inc_int,
    output logic              dec_cnt,
    output logic              done_irq
);
    seq_st_e           state;
    logic [1:0]        byte_idx;
    logic [WAIT_W-1:0] wcnt;
    logic              byte_end;
    logic              word_bytes_done;
    logic              done_q;

    assign byte_end        = (state == ST_BYTE) && (wcnt == '0);
    assign word_bytes_done = byte_end && (byte_idx == bytes_per_word(fmt) - 2'd1);

    assign bm_rd     = (state == ST_BYTE) && !dir;
    assign bm_wr     = (state == ST_BYTE) && dir;
    assign im_req    = (state == ST_IMEM);
    assign im_we     = (state == ST_IMEM) && !dir;
    assign shift_in  = byte_end && !dir;
    assign shift_out = byte_end && dir;
    assign load_word = (state == ST_LOAD);
    assign inc_ext   = byte_end;
    assign inc_int   = im_req;
    assign dec_cnt   = ((state == ST_IMEM) && !dir) || (word_bytes_done && dir);
    assign done_irq  = done_q;

    // Completion pulse: registered on the decrement that empties the count.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= dec_cnt && cnt_last;
    end

    // State machine: idle, arbitrate, strobe, internal access, word load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            byte_idx <= '0;
            wcnt     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    byte_idx <= '0;
                    if (cnt_nz) state <= dir ? ST_IMEM : ST_ARB;
                end
                ST_ARB: begin
                    if (!core_ext_req) begin
                        state <= ST_BYTE;
                        wcnt  <= wait_cnt;
                    end
                end
                ST_BYTE: begin
                    if (wcnt != '0) begin
                        wcnt <= wcnt - WAIT_W'(1);
                    end else if (word_bytes_done) begin
                        byte_idx <= '0;
                        if (dir) state <= cnt_last ? ST_IDLE : ST_IMEM;
                        else     state <= ST_IMEM;
                    end else begin
                        byte_idx <= byte_idx + 2'd1;
                        state    <= ST_ARB;
                    end
                end
                ST_IMEM: begin
                    if (dir) state <= ST_LOAD;
                    else     state <= cnt_last ? ST_IDLE : ST_ARB;
                end
                ST_LOAD: state <= ST_ARB;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bytemem_dma.sv
// Byte-memory DMA engine top. Connects registers, sequencer and packer and
// derives the processor hold/restart handshake. Assumes internal read data
// arrives the cycle after a read request.
module bytemem_dma
    import bdma_pkg::*;
#(
    parameter int PAGE_W     = 8,
    parameter int OFF_W      = 14,
    parameter int IADDR_W    = 14,
    parameter int CNT_W      = 14,
    parameter int WAIT_W     = 3,
    parameter int REG_W      = 14,
    parameter int BOOT_COUNT = 32,
    parameter int RESET_WAIT = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    boot_mode,
    input  logic                    reg_we,
    input  logic [SEL_W-1:0]        reg_sel,
    input  logic [REG_W-1:0]        reg_wdata,
    input  logic                    core_ext_req,
    output logic [PAGE_W+OFF_W-1:0] bm_addr,
    output logic                    bm_rd,
    output logic                    bm_wr,
    output logic [BYTE_W-1:0]       bm_wdata,
    input  logic [BYTE_W-1:0]       bm_rdata,
    output logic                    im_req,
    output logic                    im_we,
    output logic                    im_dm,
    output logic [IADDR_W-1:0]      im_addr,
    output logic [WORD_W-1:0]       im_wdata,
    input  logic [WORD_W-1:0]       im_rdata,
    output logic                    busy,
    output logic                    done_irq,
    output logic                    core_hold,
    output logic                    core_restart
);
    fmt_e              fmt;
    logic              dir, ctx, cnt_nz, cnt_last;
    logic [WAIT_W-1:0] wait_cnt;
    logic              inc_ext, inc_int, dec_cnt;
    logic              shift_in, shift_out, load_word;

    bdma_regs #(
        .PAGE_W(PAGE_W), .OFF_W(OFF_W), .IADDR_W(IADDR_W), .CNT_W(CNT_W),
        .WAIT_W(WAIT_W), .REG_W(REG_W), .BOOT_COUNT(BOOT_COUNT),
        .RESET_WAIT(RESET_WAIT)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .inc_ext(inc_ext), .inc_int(inc_int), .dec_cnt(dec_cnt),
        .fmt(fmt), .dir(dir), .ctx(ctx), .ext_addr(bm_addr),
        .int_addr(im_addr), .wait_cnt(wait_cnt),
        .cnt_nz(cnt_nz), .cnt_last(cnt_last)
    );

    bdma_seq #(.WAIT_W(WAIT_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .dir(dir), .wait_cnt(wait_cnt),
        .cnt_nz(cnt_nz), .cnt_last(cnt_last), .core_ext_req(core_ext_req),
        .bm_rd(bm_rd), .bm_wr(bm_wr), .im_req(im_req), .im_we(im_we),
        .shift_in(shift_in), .shift_out(shift_out), .load_word(load_word),
        .inc_ext(inc_ext), .inc_int(inc_int), .dec_cnt(dec_cnt),
        .done_irq(done_irq)
    );

    bdma_pack pack_i (
        .clk(clk), .rst_n(rst_n), .fmt(fmt),
        .load_word(load_word), .shift_in(shift_in), .shift_out(shift_out),
        .byte_in(bm_rdata), .word_in(im_rdata),
        .byte_out(bm_wdata), .word_out(im_wdata)
    );

    assign busy         = cnt_nz;
    assign im_dm        = (fmt != FMT_PM24);
    assign core_hold    = cnt_nz && ctx;
    assign core_restart = done_irq && ctx;
endmodule

// File: rtl/bytemem_dma_chk.sv
// Property checker for the byte-memory DMA engine, bound to its top.
module bytemem_dma_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_ext_req,
    input logic [ADDR_W-1:0] bm_addr,
    input logic              bm_rd,
    input logic              bm_wr,
    input logic              im_req,
    input logic              busy,
    input logic              done_irq,
    input logic              core_hold,
    input logic              core_restart
);
    // R5
    im_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        im_req |=> !im_req);

    // R6
    ext_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bm_rd || bm_wr) |-> !$past(core_ext_req));

    // R3
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bm_rd || bm_wr) && $past(bm_rd || bm_wr)) |-> $stable(bm_addr));

    // R4
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R4
    irq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (!busy && $past(busy)));

    // R7
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_hold |-> busy);

    // R7
    restart_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_restart |-> ($past(core_hold) && done_irq));
endmodule

bind bytemem_dma bytemem_dma_chk #(.ADDR_W(PAGE_W + OFF_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .core_ext_req(core_ext_req),
    .bm_addr(bm_addr), .bm_rd(bm_rd), .bm_wr(bm_wr), .im_req(im_req),
    .busy(busy), .done_irq(done_irq), .core_hold(core_hold),
    .core_restart(core_restart)
);

// File: tb/bytemem_dma_tb_top.sv
// Directed bench for the byte-memory DMA engine.
module bytemem_dma_tb_top;
    import bdma_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_mode = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [13:0] reg_wdata = '0;
    logic        core_ext_req = 1'b0;
    logic [21:0] bm_addr;
    logic        bm_rd, bm_wr;
    logic [7:0]  bm_wdata, bm_rdata;
    logic        im_req, im_we, im_dm;
    logic [13:0] im_addr;
    logic [23:0] im_wdata;
    logic [23:0] im_rdata = '0;
    logic        busy, done_irq, core_hold, core_restart;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    bytemem_dma dut_i (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .core_ext_req(core_ext_req),
        .bm_addr(bm_addr), .bm_rd(bm_rd), .bm_wr(bm_wr),
        .bm_wdata(bm_wdata), .bm_rdata(bm_rdata),
        .im_req(im_req), .im_we(im_we), .im_dm(im_dm), .im_addr(im_addr),
        .im_wdata(im_wdata), .im_rdata(im_rdata),
        .busy(busy), .done_irq(done_irq), .core_hold(core_hold),
        .core_restart(core_restart)
    );

    function automatic logic [7:0] ext_byte(input logic [21:0] a);
        return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'hA5;
    endfunction

    function automatic logic [23:0] int_word(input logic [13:0] a);
        return {a[7:0] ^ 8'h3C, a[13:6] + 8'h11, ~a[7:0]};
    endfunction

    function automatic logic [13:0] ctrl_word(input logic [1:0] f, input logic d,
                                              input logic c, input logic [7:0] pg);
        return {2'b00, pg, c, d, f};
    endfunction

    // Models of the byte memory and internal RAM read path.
    assign bm_rdata = ext_byte(bm_addr);
    always @(posedge clk) if (im_req && !im_we) im_rdata <= int_word(im_addr);

    // Activity logs, sampled 2 ns after each rising edge.
    logic [13:0] iw_addr [0:511];
    logic [23:0] iw_data [0:511];
    logic        iw_dm   [0:511];
    int          iw_n = 0;
    logic [21:0] ba_addr [0:1023];
    logic [7:0]  ba_data [0:1023];
    logic        ba_wr   [0:1023];
    int          ba_n = 0;
    int          stb_cyc = 0, irq_n = 0, rs_n = 0, prio_bad = 0;
    logic        prev_stb = 1'b0;

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (im_req && im_we && iw_n < 512) begin
                iw_addr[iw_n] = im_addr;
                iw_data[iw_n] = im_wdata;
                iw_dm[iw_n]   = im_dm;
                iw_n++;
            end
            if ((bm_rd || bm_wr) && !prev_stb && ba_n < 1024) begin
                if (core_ext_req) prio_bad++;
                ba_addr[ba_n] = bm_addr;
                ba_data[ba_n] = bm_wdata;
                ba_wr[ba_n]   = bm_wr;
                ba_n++;
            end
            if (bm_rd || bm_wr) stb_cyc++;
            if (done_irq) irq_n++;
            if (core_restart) rs_n++;
        end
        prev_stb = bm_rd || bm_wr;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic boot);
        @(negedge clk);
        rst_n = 1'b0;
        boot_mode = boot;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        boot_mode = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [13:0] val);
        @(negedge clk);
        reg_we = 1'b1;
        reg_sel = sel;
        reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_done(input string req, input int lim);
        int base = irq_n;
        int n = 0;
        while (irq_n == base && n < lim) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
        chk(irq_n == base + 1, req, irq_n - base, 1);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk(busy == 1'b0, "R11 busy", busy, 0);
        chk(!bm_rd && !bm_wr && !im_req, "R11 strobes", {bm_rd, bm_wr, im_req}, 0);
        chk(!done_irq && !core_hold, "R11 irq/hold", {done_irq, core_hold}, 0);
    endtask

    task automatic t_boot();
        int b;
        int s;
        int r;
        b = iw_n; s = stb_cyc; r = rs_n;
        do_reset(1'b1);
        chk(busy == 1'b1, "R8 boot starts", busy, 1);
        chk(core_hold == 1'b1, "R8 R7 boot hold", core_hold, 1);
        wait_done("R8 boot done", 3000);
        chk(iw_n - b == 32, "R8 boot word count", iw_n - b, 32);
        for (int k = 0; k < 32; k++) begin
            logic [23:0] e;
            e = {ext_byte(22'(3*k)), ext_byte(22'(3*k+1)), ext_byte(22'(3*k+2))};
            chk(iw_addr[b+k] == 14'(k) && iw_data[b+k] == e && iw_dm[b+k] == 1'b0,
                "R8 R1 boot word", iw_data[b+k], e);
        end
        chk(stb_cyc - s == 96*8, "R5 reset wait 7", stb_cyc - s, 96*8);
        chk(rs_n - r == 1, "R7 boot restart", rs_n - r, 1);
        chk(core_hold == 1'b0, "R7 hold released", core_hold, 0);
    endtask

    task automatic t_dm16_page();
        int b;
        int a;
        b = iw_n; a = ba_n;
        wr(SEL_WAIT, 14'd0);
        wr(SEL_CTRL, ctrl_word(2'b01, 1'b0, 1'b0, 8'd3));
        wr(SEL_EOFF, 14'h3FFF);
        wr(SEL_IADDR, 14'h100);
        wr(SEL_COUNT, 14'd2);
        chk(busy == 1'b1 && core_hold == 1'b0, "R7 no hold ctx0", {busy, core_hold}, 2'b10);
        wait_done("R4 dm16 done", 200);
        chk(ba_n - a == 4, "R1 dm16 bytes", ba_n - a, 4);
        chk(ba_addr[a] == 22'h0FFFF, "R3 page start", ba_addr[a], 22'h0FFFF);
        chk(ba_addr[a+1] == 22'h10000, "R3 page carry", ba_addr[a+1], 22'h10000);
        chk(iw_addr[b] == 14'h100 && iw_dm[b] == 1'b1, "R9 dm16 addr", iw_addr[b], 14'h100);
        chk(iw_data[b] == {8'h00, ext_byte(22'h0FFFF), ext_byte(22'h10000)},
            "R1 dm16 word0", iw_data[b], {8'h00, ext_byte(22'h0FFFF), ext_byte(22'h10000)});
        chk(iw_addr[b+1] == 14'h101 &&
            iw_data[b+1] == {8'h00, ext_byte(22'h10001), ext_byte(22'h10002)},
            "R1 R9 dm16 word1", iw_data[b+1], {8'h00, ext_byte(22'h10001), ext_byte(22'h10002)});
        chk(busy == 1'b0, "R4 idle after", busy, 0);
    endtask

    task automatic t_byte8();
        int b;
        b = iw_n;
        wr(SEL_CTRL, ctrl_word(2'b10, 1'b0, 1'b0, 8'd0));
        wr(SEL_EOFF, 14'h10);
        wr(SEL_IADDR, 14'h20);
        wr(SEL_COUNT, 14'd2);
        wait_done("R4 hi8 done", 200);
        chk(iw_data[b] == {8'h00, ext_byte(22'h10), 8'h00}, "R2 hi8 lane",
            iw_data[b], {8'h00, ext_byte(22'h10), 8'h00});
        chk(iw_data[b+1] == {8'h00, ext_byte(22'h11), 8'h00}, "R2 hi8 second",
            iw_data[b+1], {8'h00, ext_byte(22'h11), 8'h00});
        wr(SEL_CTRL, ctrl_word(2'b11, 1'b0, 1'b0, 8'd0));
        wr(SEL_EOFF, 14'h40);
        wr(SEL_COUNT, 14'd1);
        wait_done("R4 lo8 done", 200);
        chk(iw_data[b+2] == {16'h0000, ext_byte(22'h40)} && iw_dm[b+2],
            "R2 lo8 lane", iw_data[b+2], {16'h0000, ext_byte(22'h40)});
    endtask

    task automatic t_write();
        int b;
        int a;
        logic [23:0] w7, w8, w9, w20;
        b = iw_n; a = ba_n;
        w7 = int_word(14'h7); w8 = int_word(14'h8);
        w9 = int_word(14'h9); w20 = int_word(14'h20);
        wr(SEL_CTRL, ctrl_word(2'b00, 1'b1, 1'b0, 8'd1));
        wr(SEL_EOFF, 14'h200);
        wr(SEL_IADDR, 14'h7);
        wr(SEL_COUNT, 14'd2);
        wait_done("R9 wr24 done", 300);
        chk(ba_n - a == 6 && ba_wr[a], "R9 wr24 bytes", ba_n - a, 6);
        chk(ba_addr[a] == 22'h4200 && ba_addr[a+5] == 22'h4205, "R3 wr24 addr",
            ba_addr[a+5], 22'h4205);
        chk(ba_data[a] == w7[23:16] && ba_data[a+1] == w7[15:8] && ba_data[a+2] == w7[7:0],
            "R1 wr24 msb first", {ba_data[a], ba_data[a+1], ba_data[a+2]}, w7);
        chk(ba_data[a+3] == w8[23:16] && ba_data[a+5] == w8[7:0], "R9 wr24 next word",
            {ba_data[a+3], ba_data[a+5]}, {w8[23:16], w8[7:0]});
        wr(SEL_CTRL, ctrl_word(2'b01, 1'b1, 1'b0, 8'd1));
        wr(SEL_EOFF, 14'h300);
        wr(SEL_IADDR, 14'h9);
        wr(SEL_COUNT, 14'd1);
        wait_done("R9 wr16 done", 200);
        chk(ba_n - a == 8 && ba_data[a+6] == w9[15:8] && ba_data[a+7] == w9[7:0],
            "R1 wr16 bytes", {ba_data[a+6], ba_data[a+7]}, w9[15:0]);
        wr(SEL_CTRL, ctrl_word(2'b11, 1'b1, 1'b0, 8'd1));
        wr(SEL_EOFF, 14'h310);
        wr(SEL_IADDR, 14'h20);
        wr(SEL_COUNT, 14'd1);
        wait_done("R9 wr8 done", 200);
        chk(ba_n - a == 9 && ba_addr[a+8] == 22'h4310 && ba_data[a+8] == w20[7:0],
            "R1 wr lo8 byte", ba_data[a+8], w20[7:0]);
        chk(iw_n == b, "R9 no internal writes", iw_n - b, 0);
    endtask

    task automatic t_wait();
        int b;
        int a;
        int s;
        b = iw_n; a = ba_n; s = stb_cyc;
        wr(SEL_WAIT, 14'd3);
        wr(SEL_CTRL, ctrl_word(2'b11, 1'b0, 1'b0, 8'd0));
        wr(SEL_EOFF, 14'h50);
        wr(SEL_IADDR, 14'h30);
        wr(SEL_COUNT, 14'd2);
        wait_done("R5 wait done", 200);
        chk(ba_n - a == 2, "R5 accesses", ba_n - a, 2);
        chk(stb_cyc - s == 8, "R5 strobe length", stb_cyc - s, 8);
        chk(iw_n - b == 2, "R5 one request per word", iw_n - b, 2);
    endtask

    task automatic t_prio();
        int b;
        int a;
        b = iw_n; a = ba_n;
        wr(SEL_WAIT, 14'd0);
        wr(SEL_CTRL, ctrl_word(2'b00, 1'b0, 1'b0, 8'd0));
        wr(SEL_EOFF, 14'h60);
        wr(SEL_IADDR, 14'h40);
        @(negedge clk);
        core_ext_req = 1'b1;
        wr(SEL_COUNT, 14'd1);
        repeat (20) @(negedge clk);
        chk(ba_n == a && busy, "R6 held off", ba_n - a, 0);
        core_ext_req = 1'b0;
        wait_done("R6 done", 200);
        chk(ba_n - a == 3 && prio_bad == 0, "R6 no access under request", prio_bad, 0);
        chk(iw_data[b] == {ext_byte(22'h60), ext_byte(22'h61), ext_byte(22'h62)},
            "R6 data intact", iw_data[b], {ext_byte(22'h60), ext_byte(22'h61), ext_byte(22'h62)});
    endtask

    task automatic t_ignore();
        int b;
        int r;
        b = iw_n;
        wr(SEL_WAIT, 14'd2);
        wr(SEL_CTRL, ctrl_word(2'b01, 1'b0, 1'b0, 8'd0));
        wr(SEL_EOFF, 14'h70);
        wr(SEL_IADDR, 14'h50);
        wr(SEL_COUNT, 14'd3);
        wr(SEL_COUNT, 14'd10);
        wr(SEL_CTRL, ctrl_word(2'b00, 1'b0, 1'b1, 8'd5));
        wr(SEL_IADDR, 14'h3FF);
        chk(core_hold == 1'b0, "R10 ctx write ignored", core_hold, 0);
        wait_done("R10 done", 400);
        r = irq_n;
        chk(iw_n - b == 3, "R10 count write ignored", iw_n - b, 3);
        chk(iw_dm[b+2] && iw_addr[b] == 14'h50 && iw_addr[b+2] == 14'h52,
            "R10 config write ignored", iw_addr[b+2], 14'h52);
        repeat (30) @(negedge clk);
        chk(busy == 1'b0 && irq_n == r, "R10 no extra run", busy, 0);
    endtask

    task automatic t_zero();
        int a;
        int b;
        a = ba_n; b = iw_n;
        wr(SEL_COUNT, 14'd0);
        repeat (10) @(negedge clk);
        chk(busy == 1'b0 && ba_n == a && iw_n == b, "R4 zero count no start",
            ba_n - a, 0);
    endtask

    task automatic t_ctx();
        int r;
        r = rs_n;
        wr(SEL_CTRL, ctrl_word(2'b11, 1'b0, 1'b1, 8'd0));
        wr(SEL_EOFF, 14'h80);
        wr(SEL_IADDR, 14'h60);
        wr(SEL_COUNT, 14'd1);
        chk(core_hold == 1'b1, "R7 hold during run", core_hold, 1);
        wait_done("R7 ctx done", 200);
        chk(rs_n - r == 1, "R7 restart pulse", rs_n - r, 1);
        chk(core_hold == 1'b0, "R7 hold released", core_hold, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_boot();
        t_dm16_page();
        t_byte8();
        t_write();
        t_wait();
        t_prio();
        t_ignore();
        t_zero();
        t_ctx();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule